// File: doc/BRIEF.md
# Phase-Lockable Six-Channel PWM Generator

The block produces six pulse-width-modulated outputs from one up-counting period counter. Software-side configuration (period, six compare values) is held apart from the values the counter and comparators actually use. A copy into the working set happens only at a counter restart, and only after a copy has been requested. This means a whole set of new values takes effect together at a period boundary.

Several instances can run in phase. An instance in leader role announces each counter restart with a one-cycle `sync_out` pulse. In the same cycle, `load_out` pulses if that restart also copied new values. Both pulses can be held back by a programmable number of cycles. An instance in follower role restarts its counter on `sync_in` and copies its pending values on `load_in`. A follower is normally wired to a leader's `sync_out`/`load_out`. A trap input overrides all six outputs with programmed safe levels. Counter, comparators and configuration share one clock.

Top module: `lockstep_pwm`

## Requirements
- R1: The counter (`count_out`) counts 0,1,...,P and then returns to 0, where P is the working period. Each return to 0 is a restart. With P = 0 the counter stays at 0 and a restart occurs every cycle. After reset, P and all working compare values are 0.
- R2: With a delay of 0, `sync_out` is high for exactly one cycle per restart: the cycle in which `count_out` first reads 0 after that restart.
- R3: `load_out` is high only together with `sync_out`, and only when the restart behind that pulse copied the configuration into the working set.
- R4: With a delay D > 0, the pulse pair appears D cycles later than with D = 0. A restart while a delay is running reloads the delay and yields a single pair. That pair's `load_out` is set if any of the merged restarts copied values.
- R5: A pulse on `xfer_req` arms a copy. The copy is taken at the first copy opportunity in a later cycle: a restart in leader role, or `load_in` in follower role. The copy then disarms. A request made in the very cycle of an opportunity waits for the next one. Configuration changes without a request have no effect on the outputs.
- R6: With `mode_slave` = 1 (follower role), a pulse on `sync_in` restarts the counter, so `count_out` reads 0 in the next cycle. The counter still also wraps on its own period.
- R7: In follower role, an armed copy is taken on `load_in` and not on restarts.
- R8: Output bit i of `pwm_out` follows the working compare value Ci, taken from `cfg_compare[i*CNT_W +: CNT_W]`, one cycle after the counter value it is based on. Ci = 0 gives constant low. Ci >= P gives constant high. Otherwise the bit is high while the counter is below Ci.
- R9: While `trap_in` is high, each `pwm_out` bit equals the corresponding `cfg_safe_level` bit from the next cycle on. Normal output resumes one cycle after release.
- R10: During reset `count_out`, `pwm_out`, `sync_out` and `load_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for counter and configuration |
| rst | input | 1 | Synchronous active-high reset |
| mode_slave | input | 1 | 0 = leader role, 1 = follower role |
| cfg_period | input | CNT_W | Requested period P |
| cfg_compare | input | NUM_CH*CNT_W | Requested compare values, channel i at bits i*CNT_W |
| cfg_safe_level | input | NUM_CH | Output levels forced during trap |
| cfg_delay | input | DLY_W | Cycles to hold back the sync/load pulses |
| xfer_req | input | 1 | Arms a configuration copy |
| sync_in | input | 1 | Counter restart from a leader (follower role) |
| load_in | input | 1 | Copy strobe from a leader (follower role) |
| trap_in | input | 1 | Forces outputs to safe levels |
| sync_out | output | 1 | Restart announcement pulse |
| load_out | output | 1 | Copy-happened pulse, paired with sync_out |
| pwm_out | output | NUM_CH | Match outputs, bit i = channel i |
| count_out | output | CNT_W | Current counter value |

## Verification
Two events can coincide: a copy request and a copy opportunity in the same cycle. A restart can also arrive while a delay is still counting. The bench issues requests on the exact wrap cycle, and it uses periods shorter than the delay. Random follower runs drop `sync_in`, `load_in` and requests on arbitrary cycles. A scoreboard model, built from the requirements, predicts the counter, the outputs and the pulse pair cycle by cycle. It thereby judges whether the request was deferred and the pulses merged as required.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic {ROLE_LEAD = 1'b0, ROLE_FOLLOW = 1'b1} role_e;
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import lps_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  role_e            role,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cnt,
  output logic             restart
);
  logic wrap;

  assign wrap    = (cnt >= per);
  assign restart = wrap | ((role == ROLE_FOLLOW) & sync_in);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (restart) cnt <= '0;
    else cnt <= cnt + CNT_W'(1);
  end

  // R1
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !restart |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R6
  follow_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_FOLLOW && sync_in) |=> (cnt == '0));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import lps_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  role_e                   role,
  input  logic                    restart,
  input  logic                    load_in,
  input  logic                    xfer_req,
  input  logic [CNT_W-1:0]        cfg_period,
  input  logic [NUM_CH*CNT_W-1:0] cfg_compare,
  output logic [CNT_W-1:0]        act_per,
  output logic [NUM_CH*CNT_W-1:0] act_cmp,
  output logic                    xfer_now
);
  logic pending;
  logic chance;

  assign chance   = (role == ROLE_FOLLOW) ? load_in : restart;
  assign xfer_now = pending & chance;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      act_per <= '0;
      act_cmp <= '0;
    end else begin
      pending <= (pending & ~xfer_now) | xfer_req;
      if (xfer_now) begin
        act_per <= cfg_period;
        act_cmp <= cfg_compare;
      end
    end
  end

  // R5
  hold_period_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer_now |=> $stable(act_per));
  // R5
  hold_compare_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer_now |=> $stable(act_cmp));
  // R5
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_now && !xfer_req) |=> !pending);
  // R7
  follow_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_FOLLOW && !load_in) |=> $stable(act_per));
endmodule

// File: rtl/pwm_pulse_delay.sv
module pwm_pulse_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             xfer_now,
  input  logic [DLY_W-1:0] cfg_delay,
  output logic             sync_out,
  output logic             load_out
);
  logic             busy;
  logic             flag;
  logic [DLY_W-1:0] dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      flag     <= 1'b0;
      dly      <= '0;
      sync_out <= 1'b0;
      load_out <= 1'b0;
    end else if (restart) begin
      if (cfg_delay == '0) begin
        sync_out <= 1'b1;
        load_out <= xfer_now | (busy & flag);
        busy     <= 1'b0;
        flag     <= 1'b0;
      end else begin
        sync_out <= 1'b0;
        load_out <= 1'b0;
        busy     <= 1'b1;
        dly      <= cfg_delay;
        flag     <= (busy & flag) | xfer_now;
      end
    end else if (busy) begin
      if (dly == DLY_W'(1)) begin
        sync_out <= 1'b1;
        load_out <= flag;
        busy     <= 1'b0;
        flag     <= 1'b0;
      end else begin
        sync_out <= 1'b0;
        load_out <= 1'b0;
        dly      <= dly - DLY_W'(1);
      end
    end else begin
      sync_out <= 1'b0;
      load_out <= 1'b0;
    end
  end

  // R2
  zero_delay_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && cfg_delay == '0) |=> sync_out);
  // R3
  load_pair_chk: assert property (@(posedge clk) disable iff (rst)
    load_out |-> sync_out);
  // R4
  delay_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && cfg_delay != '0) |=> !sync_out);
  // R4
  delay_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !restart && dly != DLY_W'(1)) |=> !sync_out);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] cmp,
  input  logic             trap,
  input  logic             safe_lvl,
  output logic             out
);
  logic level;

  always_comb begin
    if (cmp == '0)       level = 1'b0;
    else if (cmp >= per) level = 1'b1;
    else                 level = (cnt < cmp);
  end

  always_ff @(posedge clk) begin
    if (rst)       out <= 1'b0;
    else if (trap) out <= safe_lvl;
    else           out <= level;
  end

  // R9
  trap_level_chk: assert property (@(posedge clk) disable iff (rst)
    trap |=> (out == $past(safe_lvl)));
  // R8
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (!trap && cmp == '0) |=> !out);
endmodule

// File: rtl/lockstep_pwm.sv
module lockstep_pwm
  import lps_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 6,
  parameter int DLY_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_slave,
  input  logic [CNT_W-1:0]        cfg_period,
  input  logic [NUM_CH*CNT_W-1:0] cfg_compare,
  input  logic [NUM_CH-1:0]       cfg_safe_level,
  input  logic [DLY_W-1:0]        cfg_delay,
  input  logic                    xfer_req,
  input  logic                    sync_in,
  input  logic                    load_in,
  input  logic                    trap_in,
  output logic                    sync_out,
  output logic                    load_out,
  output logic [NUM_CH-1:0]       pwm_out,
  output logic [CNT_W-1:0]        count_out
);
  role_e                   role;
  logic                    restart;
  logic                    xfer_now;
  logic [CNT_W-1:0]        act_per;
  logic [NUM_CH*CNT_W-1:0] act_cmp;

  assign role = role_e'(mode_slave);

  pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .role(role), .sync_in(sync_in),
    .per(act_per), .cnt(count_out), .restart(restart)
  );

  pwm_shadow #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_shadow (
    .clk(clk), .rst(rst), .role(role), .restart(restart),
    .load_in(load_in), .xfer_req(xfer_req),
    .cfg_period(cfg_period), .cfg_compare(cfg_compare),
    .act_per(act_per), .act_cmp(act_cmp), .xfer_now(xfer_now)
  );

  pwm_pulse_delay #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .restart(restart), .xfer_now(xfer_now),
    .cfg_delay(cfg_delay), .sync_out(sync_out), .load_out(load_out)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt(count_out), .per(act_per),
      .cmp(act_cmp[i*CNT_W +: CNT_W]), .trap(trap_in),
      .safe_lvl(cfg_safe_level[i]), .out(pwm_out[i])
    );
  end

  // R3
  load_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
    load_out |-> sync_out);
endmodule

// File: tb/lockstep_pwm_test.sv
module lockstep_pwm_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int NC = 6;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_slave = 1'b0;
  logic [CW-1:0] cfg_period = '0;
  logic [NC*CW-1:0] cfg_compare = '0;
  logic [NC-1:0] cfg_safe_level = '0;
  logic [DW-1:0] cfg_delay = '0;
  logic xfer_req = 1'b0, sync_in = 1'b0, load_in = 1'b0, trap_in = 1'b0;
  logic sync_out, load_out;
  logic [NC-1:0] pwm_out;
  logic [CW-1:0] count_out;

  lockstep_pwm #(.CNT_W(CW), .NUM_CH(NC), .DLY_W(DW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string t_cnt = "R1", t_pwm = "R8", t_sync = "R2", t_load = "R3";

  // scoreboard item: {cnt, pwm, sync, load}
  logic [CW+NC+1:0] expq[$];

  // reference model, from the requirements
  logic [CW-1:0] m_cnt, m_per, m_cmp[NC], m_dly;
  logic m_pend, m_busy, m_flag, m_sync, m_load;
  logic [NC-1:0] m_pwm;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_per = '0; m_dly = '0;
      for (int i = 0; i < NC; i++) m_cmp[i] = '0;
      m_pend = 0; m_busy = 0; m_flag = 0; m_sync = 0; m_load = 0; m_pwm = '0;
    end else begin
      logic ev, xf;
      ev = (m_cnt >= m_per) || (mode_slave && sync_in);
      xf = m_pend && (mode_slave ? load_in : ev);
      for (int i = 0; i < NC; i++) begin
        if (trap_in) m_pwm[i] = cfg_safe_level[i];
        else if (m_cmp[i] == 0) m_pwm[i] = 0;
        else if (m_cmp[i] >= m_per) m_pwm[i] = 1;
        else m_pwm[i] = (m_cnt < m_cmp[i]);
      end
      if (ev) begin
        if (cfg_delay == 0) begin
          m_sync = 1; m_load = xf || (m_busy && m_flag); m_busy = 0; m_flag = 0;
        end else begin
          m_sync = 0; m_load = 0;
          m_flag = (m_busy && m_flag) || xf; m_busy = 1; m_dly = cfg_delay;
        end
      end else if (m_busy) begin
        if (m_dly == 1) begin
          m_sync = 1; m_load = m_flag; m_busy = 0; m_flag = 0;
        end else begin
          m_sync = 0; m_load = 0; m_dly = m_dly - 1;
        end
      end else begin
        m_sync = 0; m_load = 0;
      end
      m_cnt = ev ? '0 : m_cnt + 1;
      if (xf) begin
        m_per = cfg_period;
        for (int i = 0; i < NC; i++) m_cmp[i] = cfg_compare[i*CW +: CW];
      end
      m_pend = (m_pend && !xf) || xfer_req;
    end
    expq.push_back({m_cnt, m_pwm, m_sync, m_load});
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [CW+NC+1:0] e;
      e = expq.pop_front();
      chk(t_cnt, "count_out", count_out, e[CW+NC+1:NC+2]);
      chk(trap_in ? "R9" : t_pwm, "pwm_out", pwm_out, e[NC+1:2]);
      chk(t_sync, "sync_out", sync_out, e[1]);
      chk(t_load, "load_out", load_out, e[0]);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request();
    xfer_req = 1; cyc(1); xfer_req = 0;
  endtask

  task automatic set_cmp(input int c0, c1, c2, c3, c4, c5);
    cfg_compare = {CW'(c5), CW'(c4), CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
  endtask

  task automatic rand_cfg();
    cfg_period = CW'($urandom_range(0, 24));
    for (int i = 0; i < NC; i++)
      cfg_compare[i*CW +: CW] = CW'($urandom_range(0, 27));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R10 reset state
    chk("R10", "count_out", count_out, 0);
    chk("R10", "pwm_out", pwm_out, 0);
    chk("R10", "sync_out", sync_out, 0);
    chk("R10", "load_out", load_out, 0);
    rst = 0;
    cyc(4);                         // R1 period 0: restart every cycle
    // leader, no delay: R1 R2 R3 R8
    cfg_period = 9; set_cmp(0, 3, 5, 9, 12, 1); cfg_safe_level = 6'b101010;
    request(); cyc(40);
    // R5: changes without a request are ignored
    t_pwm = "R5"; t_cnt = "R5";
    cfg_period = 4; set_cmp(2, 2, 2, 2, 2, 2); cyc(30);
    // R5: request on the exact wrap cycle waits one more period
    while (count_out != 9) cyc(1);
    request(); cyc(30);
    t_pwm = "R8"; t_cnt = "R1";
    // R4 delay
    t_sync = "R4"; t_load = "R4";
    cfg_delay = 3; cfg_period = 7; set_cmp(1, 4, 6, 7, 0, 3); request(); cyc(40);
    cfg_delay = 5; cfg_period = 2; request(); cyc(30);       // restarts merge
    cfg_period = 12; request(); cyc(45);
    // R9 trap
    trap_in = 1; cyc(6); trap_in = 0; cyc(10);
    cfg_safe_level = 6'b010101; trap_in = 1; cyc(3); trap_in = 0; cyc(5);
    // R1 period zero, with delay 0
    t_sync = "R2"; t_load = "R3";
    cfg_delay = 0; cfg_period = 0; request(); cyc(12);
    // follower role: R6 R7
    t_cnt = "R6"; t_pwm = "R7"; t_load = "R7";
    mode_slave = 1; cfg_period = 20; request();
    for (int k = 0; k < 700; k++) begin
      sync_in  = ($urandom_range(0, 6) == 0);
      load_in  = ($urandom_range(0, 4) == 0);
      xfer_req = ($urandom_range(0, 9) == 0);
      if (xfer_req) rand_cfg();
      if (k % 200 == 100) cfg_delay = DW'($urandom_range(0, 4));
      cyc(1);
    end
    sync_in = 0; load_in = 0; xfer_req = 0;
    // random leader run: R4 R5 R8
    t_cnt = "R1"; t_pwm = "R8"; t_sync = "R4"; t_load = "R4";
    mode_slave = 0;
    for (int k = 0; k < 900; k++) begin
      xfer_req = ($urandom_range(0, 7) == 0);
      if (xfer_req) rand_cfg();
      trap_in = ($urandom_range(0, 40) == 0);
      if (k % 150 == 0) cfg_delay = DW'($urandom_range(0, 9));
      cyc(1);
    end
    xfer_req = 0; trap_in = 0;
    cyc(5);
    done = 1;
    summary();
    $finish;
  end
endmodule